// File: doc/BRIEF.md
# Frame-Sync Driven UART Transmitter

This block produces an 8-N-1 asynchronous serial stream with the timing discipline of a synchronous serial port. Bytes are queued in a small transmit FIFO. A bit-clock divider produces one bit period per baud interval. A frame counter raises an internal frame sync once every thirteen bit periods. At each frame sync one byte is taken from the FIFO, wrapped into an 11-bit word and shifted out least-significant bit first. The two bit periods left over in every frame keep the line high, so characters are always separated by idle time.

Software fills the FIFO, which is allowed while the port is disabled, and then raises the enable. The hold-empty flag only says that the FIFO has drained. The separate idle output also waits for the final stop bit to leave the line, so it marks the point at which the port can be turned off safely. A frame sync that finds nothing to send sets a sticky underflow flag.

Top module: `fsync_uart_tx`

## Requirements
- R1: After reset the line is high, hold_empty is 1, fifo_full is 0, underflow is 0 and tx_idle is 1.
- R2: While enabled, one bit period lasts 2*(bit_div+1) clock cycles, and each bit of a word stays on the line for exactly one bit period.
- R3: Each byte goes out as an 11-bit word, least-significant bit first. Word bit 0 is a high idle bit, bit 1 is a low start bit, bits 2 to 9 carry data bits 0 to 7, and bit 10 is a high stop bit. The line is high at every other time.
- R4: The first frame sync comes on the 13th bit-period boundary after enable, and later frame syncs come every 13 bit periods. A word is loaded on a frame-sync boundary and word bit 0 occupies the period that follows it. The start bit of the first word therefore falls 14 bit periods after enable, and consecutive start bits are 13 bit periods apart.
- R5: The FIFO holds 8 bytes in write order. fifo_full is 1 while it holds 8, and a write made while it is full is dropped, even if a byte leaves the FIFO on the same cycle.
- R6: hold_empty is 1 whenever the FIFO holds no byte, including the time while the last word is still being shifted out.
- R7: A frame sync that finds the FIFO empty sets underflow. underflow stays set until a cycle with uf_clear at 1, and a set on the same cycle as a clear wins.
- R8: tx_idle is 1 only when the FIFO is empty and no word is on the line. It rises at the bit-period boundary that ends the stop bit.
- R9: While tx_en is 0 the line is high, the bit and frame counters are held at zero, no byte is taken from the FIFO, and writes are still accepted. Dropping tx_en during a word abandons that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_en | input | 1 | Transmit enable |
| bit_div | input | DIV_W | Bit-clock divider; bit period is 2*(bit_div+1) cycles; change only while disabled |
| wr_valid | input | 1 | Write one byte into the FIFO this cycle |
| wr_data | input | 8 | Byte to write |
| uf_clear | input | 1 | Clears the underflow flag |
| tx_line | output | 1 | Serial output, idle high |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH bytes |
| hold_empty | output | 1 | FIFO holds no byte |
| underflow | output | 1 | Sticky: a frame sync found the FIFO empty |
| tx_idle | output | 1 | FIFO empty and shifter finished |

## Verification
Every cycle, the assertions check the following: bit ticks are never adjacent, a frame sync never arrives while a word is still shifting, the line is high while disabled or idle, underflow holds until cleared, and the FIFO stays full or empty when nothing moves it. Only the bench scenarios can show the absolute timing. These cover the 14-period start of the first word, the 13-period frame spacing, the exact width of a bit, word layout across several data patterns, bytes dropped by a full FIFO, and hold_empty rising before tx_idle. A behavioural model built from queues and integers is compared with every output on every clock.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTE_W + 3;

  // bit0 idle-high, bit1 start, bits 2..9 data LSB first, bit10 stop
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [BYTE_W-1:0] d);
    return {1'b1, d, 1'b0, 1'b1};
  endfunction
endpackage

// File: rtl/fsu_timebase.sv
module fsu_timebase #(
  parameter int DIV_W  = 16,
  parameter int FS_DIV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             fsync
);
  localparam int CNT_W = DIV_W + 1;
  localparam int FS_W  = $clog2(FS_DIV + 1);
  localparam logic [FS_W-1:0] FS_LAST = FS_W'(FS_DIV);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FS_W-1:0]  fs_q, fs_d;
  logic [CNT_W-1:0] lim;

  assign lim = {div, 1'b1};

  always_comb begin
    cnt_d = cnt_q;
    fs_d  = fs_q;
    tick  = 1'b0;
    if (!en) begin
      cnt_d = '0;
      fs_d  = '0;
    end else if (cnt_q == lim) begin
      cnt_d = '0;
      tick  = 1'b1;
      fs_d  = (fs_q == FS_LAST) ? '0 : fs_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign fsync = tick && (fs_q == FS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fs_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      fs_q  <= fs_d;
    end
  end

  // R2: a bit period is at least two cycles
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/fsu_fifo.sv
module fsu_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  // R5: a full FIFO with no pop stays full (extra writes dropped)
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  // R6: an empty FIFO with no write stays empty
  a_r6_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
endmodule

// File: rtl/fsu_shifter.sv
module fsu_shifter
  import fsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              fsync,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              uf_clear,
  output logic              pop,
  output logic              line,
  output logic              busy,
  output logic              underflow
);
  localparam int SH_W   = FRAME_W - 1;
  localparam int LEFT_W = $clog2(FRAME_W);

  logic [SH_W-1:0]   sh_q, sh_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              line_q, line_d, busy_q, busy_d, uf_q, uf_d;
  logic [FRAME_W-1:0] word;

  assign word = pack_frame(fifo_data);
  assign pop  = fsync && !fifo_empty;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    line_d = line_q;
    busy_d = busy_q;
    uf_d   = uf_q;
    if (uf_clear) uf_d = 1'b0;
    if (!en) begin
      left_d = '0;
      line_d = 1'b1;
      busy_d = 1'b0;
    end else if (tick) begin
      if (pop) begin
        line_d = word[0];
        sh_d   = word[FRAME_W-1:1];
        left_d = LEFT_W'(SH_W);
        busy_d = 1'b1;
      end else if (left_q != '0) begin
        line_d = sh_q[0];
        sh_d   = sh_q >> 1;
        left_d = left_q - 1'b1;
      end else begin
        line_d = 1'b1;
        busy_d = 1'b0;
      end
      if (fsync && fifo_empty) uf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      line_q <= 1'b1;
      busy_q <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      line_q <= line_d;
      busy_q <= busy_d;
      uf_q   <= uf_d;
    end
  end

  assign line      = line_q;
  assign busy      = busy_q;
  assign underflow = uf_q;

  // R4: the previous word has fully shifted before the next frame sync
  a_r4_word_done_at_fs: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |-> (left_q == '0));
  // R7: underflow is sticky until cleared
  a_r7_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q && !uf_clear) |=> uf_q);
  // R9: disabled means line high
  a_r9_line_high_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> line_q);
endmodule

// File: rtl/fsync_uart_tx.sv
module fsync_uart_tx
  import fsu_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int FS_DIV     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              uf_clear,
  output logic              tx_line,
  output logic              fifo_full,
  output logic              hold_empty,
  output logic              underflow,
  output logic              tx_idle
);
  logic [1:0]        rsync_q;
  logic              core_rst_n;
  logic              tick, fsync, pop, busy;
  logic [BYTE_W-1:0] head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  fsu_timebase #(.DIV_W(DIV_W), .FS_DIV(FS_DIV)) u_tb (
    .clk(clk), .rst_n(core_rst_n), .en(tx_en), .div(bit_div),
    .tick(tick), .fsync(fsync)
  );

  fsu_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(core_rst_n), .push(wr_valid), .din(wr_data),
    .pop(pop), .dout(head), .full(fifo_full), .empty(hold_empty)
  );

  fsu_shifter u_sh (
    .clk(clk), .rst_n(core_rst_n), .en(tx_en), .tick(tick), .fsync(fsync),
    .fifo_empty(hold_empty), .fifo_data(head), .uf_clear(uf_clear),
    .pop(pop), .line(tx_line), .busy(busy), .underflow(underflow)
  );

  assign tx_idle = hold_empty && !busy;

  // R8: when idle is reported the line is high
  a_r8_idle_line_high: assert property (@(posedge clk) disable iff (!core_rst_n)
    tx_idle |-> tx_line);
endmodule

// File: tb/fsync_uart_tx_tb_top.sv
module fsync_uart_tx_tb_top;
  localparam int FSDIV = 12;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_en, wr_valid, uf_clear;
  logic [15:0] bit_div;
  logic [7:0]  wr_data;
  logic        tx_line, fifo_full, hold_empty, underflow, tx_idle;

  always #2.5 clk = ~clk;

  fsync_uart_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_div(bit_div),
    .wr_valid(wr_valid), .wr_data(wr_data), .uf_clear(uf_clear),
    .tx_line(tx_line), .fifo_full(fifo_full), .hold_empty(hold_empty),
    .underflow(underflow), .tx_idle(tx_idle)
  );

  int total = 0, bad = 0, cycles = 0;
  bit done = 0, cmp_on = 0;

  // behavioural reference
  byte unsigned q[$];
  int  m_cyc, m_fs, m_pos, sz0;
  byte unsigned m_byte;
  bit  m_line, m_uf, t_tick, t_fs;

  function automatic bit word_bit(byte unsigned b, int pos);
    if (pos == 0)  return 1'b1;
    if (pos == 1)  return 1'b0;
    if (pos == 10) return 1'b1;
    return b[pos-2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_cyc = 0; m_fs = 0; m_pos = -1; m_line = 1; m_uf = 0;
    end else begin
      sz0 = q.size(); t_tick = 0; t_fs = 0;
      if (uf_clear) m_uf = 0;
      if (!tx_en) begin
        m_cyc = 0; m_fs = 0; m_pos = -1; m_line = 1;
      end else begin
        if (m_cyc == 2 * int'(bit_div) + 1) begin m_cyc = 0; t_tick = 1; end
        else m_cyc++;
        if (t_tick) begin
          if (m_fs == FSDIV) begin t_fs = 1; m_fs = 0; end else m_fs++;
          if (t_fs && sz0 > 0) begin m_byte = q.pop_front(); m_pos = 0; end
          else if (m_pos >= 0 && m_pos < 10) m_pos++;
          else m_pos = -1;
          m_line = (m_pos < 0) ? 1'b1 : word_bit(m_byte, m_pos);
          if (t_fs && sz0 == 0) m_uf = 1;
        end
      end
      if (wr_valid && sz0 < DEPTH) q.push_back(wr_data);
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R3 tx_line", tx_line, m_line);
      check("R5 fifo_full", fifo_full, q.size() == DEPTH);
      check("R6 hold_empty", hold_empty, q.size() == 0);
      check("R7 underflow", underflow, m_uf);
      check("R8 tx_idle", tx_idle, (q.size() == 0) && (m_pos < 0));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic put(byte unsigned d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (tx_idle) break;
    end
  endtask

  initial begin
    int p, n, w;
    rst_n = 0; tx_en = 0; wr_valid = 0; wr_data = 0; uf_clear = 0; bit_div = 16'd1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    check("R1 line", tx_line, 1); check("R1 hold_empty", hold_empty, 1);
    check("R1 full", fifo_full, 0); check("R1 underflow", underflow, 0);
    check("R1 idle", tx_idle, 1);

    // R9: writes accepted while disabled, nothing leaves
    put(8'hFF); put(8'hFF);
    repeat (60) @(negedge clk);
    check("R9 line high while off", tx_line, 1);
    check("R9 no pop while off", hold_empty, 0);

    // R2/R4: start bit timing
    p = 2 * (int'(bit_div) + 1);
    tx_en = 1;
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); n++;
      if (tx_line == 0) break;
    end
    check("R4 first start bit delay", n, 14 * p);
    w = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (tx_line != 0) break;
      w++;
    end
    check("R2 start bit width", w, p);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); n++;
      if (tx_line == 0) break;
    end
    check("R4 frame spacing", n, 12 * p);

    // R6 before R8: FIFO drains before the word ends
    check("R6 hold_empty while shifting", hold_empty, 1);
    check("R8 not idle while shifting", tx_idle, 0);
    wait_idle();
    check("R8 idle after stop bit", tx_idle, 1);

    // R7 underflow set and cleared
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (underflow) break;
    end
    check("R7 underflow set", underflow, 1);
    uf_clear = 1; @(negedge clk); uf_clear = 0;
    check("R7 underflow cleared", underflow, 0);

    // R5: overfill while disabled, then drain at a faster rate
    tx_en = 0; @(negedge clk); bit_div = 16'd0;
    for (int i = 0; i < 10; i++) begin
      wr_valid = 1; wr_data = 8'(8'h10 + i); @(negedge clk);
    end
    wr_valid = 0;
    check("R5 full after overfill", fifo_full, 1);
    tx_en = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (hold_empty) break;
    end
    check("R6 empty while last word shifts", tx_idle, 0);
    wait_idle();

    // R3 data patterns
    put(8'h55); put(8'hA5); put(8'h00);
    wait_idle();
    put(8'h80); repeat (9) @(negedge clk); put(8'h01);
    wait_idle();
    check("R3 line idle high after words", tx_line, 1);

    // R9: disable during a word abandons it
    put(8'h00);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (tx_line == 0) break;
    end
    repeat (6) @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    check("R9 line high after disable mid-word", tx_line, 1);
    check("R9 idle after abandon", tx_idle, 1);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule